// File: doc/BRIEF.md
# Immediate-Data Memory Write Generator

This block turns a small immediate-data write operation into one or two PCI Express Memory Write requests. An operation carries a 64-bit destination address, a byte count and eight bytes of inline data held in two 32-bit words. The block builds the request header, works out the DWord length and the first and last byte enables, and places the payload bytes into DWord lanes according to the destination alignment. The result leaves as a stream of 32-bit words.

Each request chooses its own header size. A destination below 4 GB gets a three-DWord header with a 32-bit address. Any other destination gets a four-DWord header with a 64-bit address. A write whose bytes would run across a 4-KB page boundary is split into two requests, one on each side of the boundary. An operation with an out-of-range byte count produces no request. Every accepted operation ends with a one-cycle completion pulse.

Top module: `imm_mwr_gen`

## Requirements
- R1: A request whose start address has bits 63:32 all zero has a 3-DWord header with DW0[31:29]=010 and its third DWord = {addr[31:2],00}. Any other request has a 4-DWord header with DW0[31:29]=011, third DWord = addr[63:32] and fourth DWord = {addr[31:2],00}. In both cases DW0[28:24]=00000, DW0[23:10]=0 and DW1[31:8]=0.
- R2: DW0[9:0] holds the number of DWords the request touches, counted from the DWord-aligned start address.
- R3: DW1[3:0] is the first-DWord byte enable and DW1[7:4] is the last-DWord byte enable. Each bit marks a byte lane the request writes. When a request touches only one DWord, its last byte enable is 0000.
- R4: Byte i of the operation (i=0..7) comes from bits 8i+7:8i of {op_data_hi, op_data_lo}. It is written to destination address addr+i. In the payload this byte sits in lane (addr+i) mod 4, bits 8*lane+7:8*lane. Lanes without a byte carry zero.
- R5: When the count is 4 or less, op_data_hi has no effect on the output.
- R6: A count of 0 or above 8 is reserved. Such an operation emits no word, and done pulses in the cycle after it is accepted.
- R7: If addr+count would pass a 4-KB boundary, two requests are emitted. The first holds the bytes below the boundary. The second starts at the boundary address with the rest of the bytes. Each request picks its header size by R1 on its own address.
- R8: A word offered with out_valid high stays unchanged until out_ready is high. out_last is high on the final word of each request.
- R9: done pulses for one cycle in the cycle after the final word is accepted. op_ready is low from acceptance until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Block idle, can take an operation |
| op_addr | input | 64 | Destination byte address |
| op_count | input | 4 | Number of bytes to write |
| op_data_lo | input | 32 | Operation bytes 0 to 3 |
| op_data_hi | input | 32 | Operation bytes 4 to 7 |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink takes the word |
| out_data | output | 32 | Header or payload DWord |
| out_last | output | 1 | Final word of a request |
| done | output | 1 | Operation finished pulse |

## Verification
The page split and the choice of header size can meet in one operation. This happens when the bytes cross a 4-KB boundary that is also the 4-GB boundary, so the first request needs a 3-DWord header and the second a 4-DWord header. The bench provokes it with six bytes at address 0xFFFF_FFFD while out_ready is throttled. The handover between the two requests therefore sits under backpressure. Every word is compared against a byte-by-byte reference that places each byte by its own address, and done must follow the last word by exactly one cycle.

// File: rtl/imm_mwr_pkg.sv
package imm_mwr_pkg;
  localparam int IMM_BYTES = 8;
  localparam int CNT_W     = 4;
  localparam int SRC_W     = $clog2(IMM_BYTES);
  localparam int AW        = 64;

  localparam logic [2:0] FMT_3DW_DATA = 3'b010;
  localparam logic [2:0] FMT_4DW_DATA = 3'b011;
  localparam logic [4:0] TYPE_MEM     = 5'b00000;

  typedef struct packed {
    logic [AW-1:0]    addr;
    logic [CNT_W-1:0] nbytes;
    logic [SRC_W-1:0] src;
  } req_t;

  function automatic logic req_is64(req_t r);
    return |r.addr[AW-1:32];
  endfunction

  function automatic logic [3:0] req_len(req_t r);
    logic [5:0] s;
    s = 6'(r.addr[1:0]) + 6'(r.nbytes) + 6'd3;
    return s[5:2];
  endfunction

  function automatic logic [3:0] req_words(req_t r);
    return (req_is64(r) ? 4'd4 : 4'd3) + req_len(r);
  endfunction
endpackage

// File: rtl/imm_mwr_split.sv
module imm_mwr_split
  import imm_mwr_pkg::*;
#(
  parameter int PAGE_BITS = 12
) (
  input  logic [AW-1:0]    addr,
  input  logic [CNT_W-1:0] count,
  output req_t             r0,
  output req_t             r1,
  output logic             two,
  output logic             reserved
);
  localparam int RW = PAGE_BITS + 1;

  logic [RW-1:0] room;
  logic [RW-1:0] cnt_ext;

  assign room     = RW'(1 << PAGE_BITS) - RW'(addr[PAGE_BITS-1:0]);
  assign cnt_ext  = RW'(count);
  assign reserved = (count == '0) || (count > CNT_W'(IMM_BYTES));
  assign two      = !reserved && (cnt_ext > room);

  always_comb begin
    r0.addr   = addr;
    r0.nbytes = two ? CNT_W'(room) : count;
    r0.src    = '0;
    r1.addr   = addr + AW'(room);
    r1.nbytes = count - CNT_W'(room);
    r1.src    = SRC_W'(room);
  end
endmodule

// File: rtl/imm_mwr_word.sv
module imm_mwr_word
  import imm_mwr_pkg::*;
(
  input  req_t                   req,
  input  logic [3:0]             idx,
  input  logic [IMM_BYTES*8-1:0] data,
  output logic [31:0]            word,
  output logic                   last
);
  logic       is64;
  logic [3:0] len, hdr, k;
  logic [1:0] off, endm;
  logic [4:0] stop;
  logic [3:0] fbe, lbe;
  logic [31:0] pay;

  assign is64 = req_is64(req);
  assign len  = req_len(req);
  assign hdr  = is64 ? 4'd4 : 4'd3;
  assign off  = req.addr[1:0];
  assign stop = 5'(off) + 5'(req.nbytes);
  assign endm = stop[1:0] - 2'd1;
  assign k    = idx - hdr;
  assign last = (idx == hdr + len - 4'd1);

  always_comb begin
    for (int j = 0; j < 4; j++) begin
      fbe[j] = (5'(j) >= 5'(off)) && (5'(j) < stop);
      lbe[j] = (len != 4'd1) && (2'(j) <= endm);
    end
  end

  always_comb begin
    logic [5:0]       pos;
    logic [SRC_W-1:0] bi;
    pay = '0;
    for (int j = 0; j < 4; j++) begin
      pos = {k, 2'(j)};
      bi  = req.src + SRC_W'(pos) - SRC_W'(off);
      if ((pos >= 6'(off)) && (pos < 6'(stop)))
        pay[8*j +: 8] = data[8*bi +: 8];
    end
  end

  always_comb begin
    case (idx)
      4'd0:    word = {is64 ? FMT_4DW_DATA : FMT_3DW_DATA, TYPE_MEM, 14'b0, 6'b0, len};
      4'd1:    word = {24'b0, lbe, fbe};
      4'd2:    word = is64 ? req.addr[63:32] : {req.addr[31:2], 2'b00};
      4'd3:    word = is64 ? {req.addr[31:2], 2'b00} : pay;
      default: word = pay;
    endcase
  end
endmodule

// File: rtl/imm_mwr_gen.sv
module imm_mwr_gen
  import imm_mwr_pkg::*;
#(
  parameter int PAGE_BITS = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        op_valid,
  output logic        op_ready,
  input  logic [63:0] op_addr,
  input  logic [3:0]  op_count,
  input  logic [31:0] op_data_lo,
  input  logic [31:0] op_data_hi,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        out_last,
  output logic        done
);
  req_t        p0, p1, r0_q, r1_q, sel_req;
  logic        p_two, p_rsv, two_q, busy, cur_req;
  logic [3:0]  cur_w, sel_w;
  logic [63:0] data_q, sel_data;
  logic [31:0] sel_word;
  logic        sel_last, accept, fire;

  imm_mwr_split #(.PAGE_BITS(PAGE_BITS)) u_split (
    .addr(op_addr), .count(op_count), .r0(p0), .r1(p1), .two(p_two), .reserved(p_rsv)
  );

  imm_mwr_word u_word (
    .req(sel_req), .idx(sel_w), .data(sel_data), .word(sel_word), .last(sel_last)
  );

  assign op_ready = !busy;
  assign accept   = op_valid && !busy;
  assign fire     = out_valid && out_ready;

  always_comb begin
    if (accept) begin
      sel_req  = p0;
      sel_w    = 4'd0;
      sel_data = {op_data_hi, op_data_lo};
    end else begin
      sel_data = data_q;
      if (out_last) begin
        sel_req = r1_q;
        sel_w   = 4'd0;
      end else begin
        sel_req = cur_req ? r1_q : r0_q;
        sel_w   = cur_w + 4'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cur_req   <= 1'b0;
      cur_w     <= '0;
      two_q     <= 1'b0;
      r0_q      <= '0;
      r1_q      <= '0;
      data_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (p_rsv) begin
          done <= 1'b1;
        end else begin
          busy      <= 1'b1;
          r0_q      <= p0;
          r1_q      <= p1;
          two_q     <= p_two;
          data_q    <= {op_data_hi, op_data_lo};
          cur_req   <= 1'b0;
          cur_w     <= '0;
          out_valid <= 1'b1;
          out_data  <= sel_word;
          out_last  <= sel_last;
        end
      end else if (fire) begin
        if (out_last && (cur_req || !two_q)) begin
          out_valid <= 1'b0;
          out_last  <= 1'b0;
          busy      <= 1'b0;
          done      <= 1'b1;
        end else begin
          if (out_last) begin
            cur_req <= 1'b1;
            cur_w   <= '0;
          end else begin
            cur_w <= cur_w + 4'd1;
          end
          out_data <= sel_word;
          out_last <= sel_last;
        end
      end
    end
  end

  // R8: a stalled word must not change
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R9: no new operation while words are pending
  a_r9_busy: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !op_ready);

  // R9: done only once the stream has drained
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid);

  // R6: reserved counts produce a pulse and no words
  a_r6_reserved: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_ready && (op_count == 4'd0 || op_count > 4'd8) |=> done && !out_valid);

  // R7: second request starts exactly on a page boundary
  a_r7_aligned: assert property (@(posedge clk) disable iff (rst)
    busy && two_q |-> r1_q.addr[PAGE_BITS-1:0] == '0);

  // R2: a header DW0 carries a length of one to three DWords
  a_r2_len: assert property (@(posedge clk) disable iff (rst)
    out_valid && cur_w == 4'd0 |-> out_data[9:0] >= 10'd1 && out_data[9:0] <= 10'd3);
endmodule

// File: tb/tb_imm_mwr_gen.sv
`timescale 1ns/1ps
module tb_imm_mwr_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid, op_ready, out_valid, out_ready, out_last, done;
  logic [63:0] op_addr;
  logic [3:0]  op_count;
  logic [31:0] op_data_lo, op_data_hi, out_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [31:0] exp_w [0:15];
  logic        exp_l [0:15];
  int          exp_n;

  imm_mwr_gen dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_addr(op_addr), .op_count(op_count), .op_data_lo(op_data_lo), .op_data_hi(op_data_hi),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .done(done)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference: one request, placed byte by byte
  task automatic add_req(input logic [63:0] a, input int m, input int s, input logic [63:0] d);
    logic [95:0] pb;
    logic [11:0] pe;
    logic        is64;
    int          off, nd;
    logic [3:0]  fbe, lbe;
    pb = '0; pe = '0;
    is64 = (a[63:32] != 32'd0);
    off = int'(a[1:0]);
    nd = (off + m + 3) / 4;
    for (int i = 0; i < m; i++) begin
      pb[8*(off+i) +: 8] = d[8*(s+i) +: 8];
      pe[off+i] = 1'b1;
    end
    fbe = pe[3:0];
    lbe = (nd > 1) ? pe[4*(nd-1) +: 4] : 4'b0000;
    exp_w[exp_n] = {is64 ? 3'b011 : 3'b010, 5'b0, 14'b0, 10'(nd)}; exp_l[exp_n] = 0; exp_n++;
    exp_w[exp_n] = {24'b0, lbe, fbe}; exp_l[exp_n] = 0; exp_n++;
    if (is64) begin
      exp_w[exp_n] = a[63:32]; exp_l[exp_n] = 0; exp_n++;
    end
    exp_w[exp_n] = {a[31:2], 2'b00}; exp_l[exp_n] = 0; exp_n++;
    for (int w = 0; w < nd; w++) begin
      exp_w[exp_n] = pb[32*w +: 32]; exp_l[exp_n] = (w == nd-1); exp_n++;
    end
  endtask

  task automatic build(input logic [63:0] a, input int n, input logic [63:0] d);
    int room, n1;
    exp_n = 0;
    if (n < 1 || n > 8) return;
    room = 4096 - int'(a[11:0]);
    n1 = (n <= room) ? n : room;
    add_req(a, n1, 0, d);
    if (n1 < n) add_req(a + 64'(n1), n - n1, n1, d);
  endtask

  // mode 0: always ready, 1: ready two of three cycles, 2: mostly stalled
  task automatic run_op(input string tag, input logic [63:0] a, input int n,
                        input logic [31:0] lo, input logic [31:0] hi, input int mode);
    int k, since, guard;
    logic [31:0] pdata;
    logic        pstall;
    build(a, n, {hi, lo});
    @(negedge clk);
    op_valid = 1; op_addr = a; op_count = 4'(n); op_data_lo = lo; op_data_hi = hi;
    chk(op_ready, {tag, " R9 idle before op"}, 64'(op_ready), 64'd1);
    since = 0; k = 0; pstall = 0; pdata = '0; guard = 0;
    forever begin
      @(negedge clk);
      op_valid = 0;
      since++; guard++;
      if (guard > 300) begin
        chk(0, {tag, " R9 stream hung"}, 64'(k), 64'(exp_n));
        break;
      end
      if (pstall) chk(out_valid && out_data == pdata, {tag, " R8 held word"}, 64'(out_data), 64'(pdata));
      if (done) begin
        chk(k == exp_n, {tag, " R9 word count at done"}, 64'(k), 64'(exp_n));
        chk(since == 1, {tag, " R9/R6 done timing"}, 64'(since), 64'd1);
        break;
      end
      case (mode)
        0: out_ready = 1;
        1: out_ready = (cyc % 3) != 1;
        default: out_ready = (cyc % 4) == 0;
      endcase
      if (out_valid) chk(!op_ready, {tag, " R9 op_ready low while busy"}, 64'(op_ready), 64'd0);
      pstall = out_valid && !out_ready;
      pdata  = out_data;
      if (out_valid && out_ready) begin
        if (k < exp_n) begin
          chk(out_data == exp_w[k], tag, 64'(out_data), 64'(exp_w[k]));
          chk(out_last == exp_l[k], {tag, " R8 last flag"}, 64'(out_last), 64'(exp_l[k]));
        end else begin
          chk(0, {tag, " extra word"}, 64'(out_data), 64'd0);
        end
        k++;
        since = 0;
      end
    end
    out_ready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  task automatic t_reset;
    @(negedge clk);
    chk(!out_valid, "R9 reset out_valid", 64'(out_valid), 64'd0);
    chk(!done, "R9 reset done", 64'(done), 64'd0);
    chk(op_ready, "R9 reset op_ready", 64'(op_ready), 64'd1);
  endtask

  task automatic t_aligned32;  run_op("R1 R2 R4 aligned 32-bit", 64'h1000_0000, 4, 32'hA1B2C3D4, 32'h0, 0); endtask
  task automatic t_unaligned;  run_op("R3 R4 unaligned eight bytes", 64'h2003, 8, 32'h44332211, 32'h88776655, 0); endtask
  task automatic t_single_dw;  run_op("R3 single DWord", 64'h101, 2, 32'h0000BEEF, 32'h12345678, 0); endtask
  task automatic t_wide_addr;  run_op("R1 64-bit address", 64'h1_2345_6786, 5, 32'hCAFEF00D, 32'h000000E5, 1); endtask
  task automatic t_hi_ignored;
    run_op("R5 upper word ignored A", 64'h3001, 3, 32'h00ABCDEF, 32'hFFFFFFFF, 0);
    run_op("R5 upper word ignored B", 64'h3001, 3, 32'h00ABCDEF, 32'h5A5A5A5A, 0);
  endtask
  task automatic t_reserved;
    run_op("R6 count zero", 64'h4000, 0, 32'h1, 32'h2, 0);
    run_op("R6 count nine", 64'h4000, 9, 32'h1, 32'h2, 0);
    run_op("R6 count fifteen", 64'h1_0000_4000, 15, 32'h1, 32'h2, 0);
  endtask
  task automatic t_split;      run_op("R7 page split", 64'h7FFE, 8, 32'h04030201, 32'h08070605, 0); endtask
  task automatic t_split_4g;   run_op("R7 R1 split at 4 GB", 64'hFFFF_FFFD, 6, 32'h1F2E3D4C, 32'h00009A8B, 1); endtask
  task automatic t_backpress;  run_op("R8 R9 backpressure", 64'h40, 7, 32'h76543210, 32'h00FEDCBA, 2); endtask

  initial begin
    rst = 1; op_valid = 0; op_addr = '0; op_count = '0;
    op_data_lo = '0; op_data_hi = '0; out_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_aligned32();
    t_unaligned();
    t_single_dw();
    t_wide_addr();
    t_hi_ignored();
    t_reserved();
    t_split();
    t_split_4g();
    t_backpress();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule